// File: doc/BRIEF.md
# Debug-Port Program Memory Reader

This block lets an external debug host read one-time-programmable program memory byte by byte. The host sees six byte-wide registers, picked by a 3-bit select: a device control register, a memory control register, an address high byte, an address low byte, a data port and a status byte. The other side is a synchronous read port with one cycle of latency into a byte-wide memory.

A read session follows a fixed order. The host halts the processor core through device control. It enters read mode through memory control, loads a start address, and then reads the data port again and again. Each data read returns the byte at the pointer and moves the pointer on by one. The host leaves read mode with a two-write exit and then releases the core with a two-write release.

When read mode is entered, the block fetches a security byte from the highest memory address. Its low nibble governs reads and its high nibble governs writes. A single cleared bit in a nibble locks the whole memory for that kind of access. Locks are sticky until hardware reset.

Two state machines drive the block:
- **Device machine.** RUN moves to HOLD on command 0x04. HOLD moves to ARMED on 0x02. ARMED moves to RUN on 0x00. Command 0x04 moves to HOLD from any state.
- **Memory machine.** OFF moves to FETCH on a 0x00 write while the core is held. FETCH moves to LATCH, and LATCH moves to READ; these two steps take one cycle each. READ moves to EXIT1 on 0x40. EXIT1 moves to OFF on 0x00, or back to READ on any other value. Whenever the core is not held, the memory machine goes to OFF.

Top module: `dbg_mem_reader`

## Requirements
- R1: After reset the core is not held and no read response is pending. Status, address high and address low all read as 0x00.
- R2: Writing 0x04 to device control (select 0) holds the core from the next cycle. The core is released only after 0x02 and then 0x00 are written. A 0x00 written directly from HOLD has no effect.
- R3: Writing 0x00 to memory control (select 1) while the core is held reads the security byte at address 0xFFFF. Read mode is active two cycles after the write and shows in status bit 3.
- R4: Address high (select 2) and address low (select 3) form one 16-bit pointer, and both read back their current value.
- R5: A read of the data port (select 4) brings host_rvalid high on the next cycle, with the memory byte at the pointer. The pointer then increments by one and wraps from 0xFFFF to 0x0000.
- R6: If any of bits 3..0 of the sampled security byte is 0, every data read returns 0x00 and sets ERROR.
- R7: Status bit 0 is ERROR. Bit 1 is the read lock. Bit 2 is the write lock, which is set when any of security bits 7..4 is 0. Bit 3 is read mode. Bits 7..4 read as 0.
- R8: A data read made outside read mode, with the core not held, or while read-locked returns 0x00. It sets ERROR and still increments the pointer. ERROR clears when read mode is entered again.
- R9: Read mode ends only after 0x40 and then 0x00 are written to memory control. Any other value after 0x40 returns to read mode.
- R10: Once set, a lock flag stays set through later re-entries of read mode until hardware reset, even if the security byte then reads 0xFF.
- R11: Releasing the core while in read mode ends read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_sel | input | 3 | Register select |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read response, one cycle after host_rd |
| core_hold | output | 1 | Processor core held in reset |
| mem_re | output | 1 | Memory read enable |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Memory data, one cycle after mem_re |

## Verification
The assertions assume the host makes at most one access per cycle: a read and a write never come together. They also assume the pointer is never written in the same cycle as a data read, and that the memory returns data exactly one cycle after mem_re. The stimulus issues one access per cycle through a single task. It changes the security byte only while the memory machine is OFF, so the fetched value is stable. Every read response, and core_hold, is compared each cycle against a behavioural model.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
    typedef enum logic [2:0] {
        SEL_DEV  = 3'd0,
        SEL_MEM  = 3'd1,
        SEL_AHI  = 3'd2,
        SEL_ALO  = 3'd3,
        SEL_DATA = 3'd4,
        SEL_STAT = 3'd5
    } sel_e;

    typedef enum logic [1:0] {
        DEV_RUN,
        DEV_HOLD,
        DEV_ARMED
    } dev_e;

    typedef enum logic [2:0] {
        MS_OFF,
        MS_FETCH,
        MS_LATCH,
        MS_READ,
        MS_EXIT1
    } ms_e;

    localparam logic [7:0] CMD_HALT  = 8'h04;
    localparam logic [7:0] CMD_ARM   = 8'h02;
    localparam logic [7:0] CMD_ZERO  = 8'h00;
    localparam logic [7:0] CMD_LEAVE = 8'h40;

    localparam int ST_ERR  = 0;
    localparam int ST_RLK  = 1;
    localparam int ST_WLK  = 2;
    localparam int ST_MODE = 3;
endpackage

// File: rtl/dbg_dev_ctrl.sv
module dbg_dev_ctrl
    import dmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic [7:0] cmd,
    output logic       core_hold
);
    dev_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DEV_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (cmd_we) begin
            if (cmd == CMD_HALT) begin
                state_d = DEV_HOLD;
            end else begin
                unique case (state_q)
                    DEV_RUN:   state_d = DEV_RUN;
                    DEV_HOLD:  if (cmd == CMD_ARM)  state_d = DEV_ARMED;
                    DEV_ARMED: if (cmd == CMD_ZERO) state_d = DEV_RUN;
                    default:   state_d = DEV_RUN;
                endcase
            end
        end
    end

    always_comb begin
        core_hold = (state_q != DEV_RUN);
    end

    assert_halt_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd == CMD_HALT) |=> core_hold);

    assert_release_needs_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_hold) |-> $past(cmd_we && cmd == CMD_ZERO));
endmodule

// File: rtl/dbg_mem_seq.sv
module dbg_mem_seq
    import dmr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_hold,
    input  logic              cmd_we,
    input  logic [7:0]        cmd,
    input  logic [DATA_W-1:0] sec_byte,
    output logic              fetch,
    output logic              enter,
    output logic              read_mode,
    output logic              rd_lock,
    output logic              wr_lock
);
    localparam int HALF = DATA_W / 2;

    ms_e state_q, state_d;
    logic rd_lock_q, wr_lock_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MS_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_OFF:   if (cmd_we && cmd == CMD_ZERO && core_hold) state_d = MS_FETCH;
            MS_FETCH: state_d = MS_LATCH;
            MS_LATCH: state_d = MS_READ;
            MS_READ:  if (cmd_we && cmd == CMD_LEAVE) state_d = MS_EXIT1;
            MS_EXIT1: if (cmd_we) state_d = (cmd == CMD_ZERO) ? MS_OFF : MS_READ;
            default:  state_d = MS_OFF;
        endcase
        if (!core_hold) state_d = MS_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_lock_q <= 1'b0;
            wr_lock_q <= 1'b0;
        end else if (state_q == MS_LATCH) begin
            rd_lock_q <= rd_lock_q | (sec_byte[HALF-1:0] != {HALF{1'b1}});
            wr_lock_q <= wr_lock_q | (sec_byte[DATA_W-1:HALF] != {(DATA_W-HALF){1'b1}});
        end
    end

    always_comb begin
        fetch     = (state_q == MS_FETCH);
        enter     = (state_q == MS_LATCH);
        read_mode = (state_q == MS_READ) || (state_q == MS_EXIT1);
        rd_lock   = rd_lock_q;
        wr_lock   = wr_lock_q;
    end

    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lock && wr_lock) |=> (rd_lock && wr_lock) or !(rd_lock && wr_lock) && 1'b0 || (rd_lock && wr_lock));

    assert_rdlock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lock |=> rd_lock);

    assert_release_ends_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (read_mode && !core_hold) |=> !read_mode);

    assert_exit_needs_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(read_mode) && $past(core_hold)) |-> $past(cmd_we && cmd == CMD_ZERO));
endmodule

// File: rtl/dbg_addr_ptr.sv
module dbg_addr_ptr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_hi,
    input  logic              we_lo,
    input  logic [7:0]        wdata,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    localparam int HI_W = ADDR_W - 8;

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (we_hi || we_lo) begin
            if (we_hi) addr_q[ADDR_W-1:8] <= wdata[HI_W-1:0];
            if (we_lo) addr_q[7:0]        <= wdata;
        end else if (step) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr = addr_q;

    assert_step_incr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !we_hi && !we_lo) |=> addr == ADDR_W'($past(addr) + 1));
endmodule

// File: rtl/dbg_mem_reader.sv
module dbg_mem_reader
    import dmr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [2:0]        host_sel,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              host_rvalid,
    output logic              core_hold,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam logic [ADDR_W-1:0] SEC_ADDR = {ADDR_W{1'b1}};

    sel_e              sel;
    logic              fetch, enter, read_mode, rd_lock, wr_lock;
    logic              data_rd, grant, err_q;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        status;
    logic              resp_v_q, resp_mem_q;
    logic [7:0]        resp_byte_q;

    assign sel     = sel_e'(host_sel);
    assign data_rd = host_rd && (sel == SEL_DATA);
    assign grant   = data_rd && core_hold && read_mode && !rd_lock;

    dbg_dev_ctrl u_dev (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (host_wr && sel == SEL_DEV),
        .cmd       (host_wdata),
        .core_hold (core_hold)
    );

    dbg_mem_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .core_hold (core_hold),
        .cmd_we    (host_wr && sel == SEL_MEM),
        .cmd       (host_wdata),
        .sec_byte  (mem_rdata),
        .fetch     (fetch),
        .enter     (enter),
        .read_mode (read_mode),
        .rd_lock   (rd_lock),
        .wr_lock   (wr_lock)
    );

    dbg_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .we_hi (host_wr && sel == SEL_AHI),
        .we_lo (host_wr && sel == SEL_ALO),
        .wdata (host_wdata),
        .step  (data_rd),
        .addr  (addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                err_q <= 1'b0;
        else if (enter)            err_q <= 1'b0;
        else if (data_rd && !grant) err_q <= 1'b1;
    end

    always_comb begin
        status          = '0;
        status[ST_ERR]  = err_q;
        status[ST_RLK]  = rd_lock;
        status[ST_WLK]  = wr_lock;
        status[ST_MODE] = read_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_v_q    <= 1'b0;
            resp_mem_q  <= 1'b0;
            resp_byte_q <= '0;
        end else begin
            resp_v_q   <= host_rd;
            resp_mem_q <= grant;
            resp_byte_q <= '0;
            if (host_rd) begin
                unique case (sel)
                    SEL_AHI:  resp_byte_q <= 8'(addr >> 8);
                    SEL_ALO:  resp_byte_q <= addr[7:0];
                    SEL_STAT: resp_byte_q <= status;
                    default:  resp_byte_q <= '0;
                endcase
            end
        end
    end

    always_comb begin
        mem_re      = fetch || grant;
        mem_addr    = fetch ? SEC_ADDR : addr;
        host_rvalid = resp_v_q;
        host_rdata  = resp_mem_q ? 8'(mem_rdata) : resp_byte_q;
    end

    assert_denied_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !grant) |=> (host_rvalid && host_rdata == 8'h00));

    assert_locked_no_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lock && data_rd) |-> !mem_re);
endmodule

// File: tb/dbg_mem_reader_tb_top.sv
module dbg_mem_reader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0]  host_sel = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_rvalid, core_hold, mem_re;
    logic [15:0] mem_addr;
    logic [7:0]  mem_q = '0;
    logic [7:0]  sec_byte = 8'hFF;

    int checks = 0, fails = 0, cycles = 0;
    string tag = "R1";

    // behavioural reference state
    int        m_dev = 0;   // 0 run, 1 hold, 2 armed
    int        m_mode = 0;  // 0 off, 1 fetch, 2 latch, 3 read, 4 exit1
    bit [15:0] m_addr = 0;
    bit        m_err = 0, m_rl = 0, m_wl = 0;
    bit        e_v = 0;
    bit [7:0]  e_d = 0;

    always #2 clk = ~clk;

    dbg_mem_reader dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .core_hold(core_hold), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_rdata(mem_q)
    );

    function automatic bit [7:0] memf(bit [15:0] a);
        if (a == 16'hFFFF) return sec_byte;
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    always_ff @(posedge clk) if (mem_re) mem_q <= memf(mem_addr);

    task automatic check(string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(bit wr, bit rd, int sel, bit [7:0] wd);
        int        dev_n = m_dev, mode_n = m_mode;
        bit [15:0] addr_n = m_addr;
        bit        err_n = m_err;
        bit        rmode = (m_mode == 3 || m_mode == 4);
        host_wr = wr; host_rd = rd; host_sel = 3'(sel); host_wdata = wd;
        @(posedge clk);
        e_v = rd; e_d = 0;
        if (rd) begin
            case (sel)
                2: e_d = m_addr[15:8];
                3: e_d = m_addr[7:0];
                5: e_d = {4'b0, rmode, m_wl, m_rl, m_err};
                4: begin
                    if (m_dev != 0 && rmode && !m_rl) e_d = memf(m_addr);
                    else err_n = 1;
                    addr_n = m_addr + 1;
                end
                default: e_d = 0;
            endcase
        end
        if (wr) begin
            case (sel)
                0: if (wd == 8'h04) dev_n = 1;
                   else if (m_dev == 1 && wd == 8'h02) dev_n = 2;
                   else if (m_dev == 2 && wd == 8'h00) dev_n = 0;
                1: if (m_mode == 0 && wd == 8'h00 && m_dev != 0) mode_n = 1;
                   else if (m_mode == 3 && wd == 8'h40) mode_n = 4;
                   else if (m_mode == 4) mode_n = (wd == 8'h00) ? 0 : 3;
                2: addr_n[15:8] = wd;
                3: addr_n[7:0] = wd;
                default: ;
            endcase
        end
        if (m_mode == 1) mode_n = 2;
        if (m_mode == 2) begin
            mode_n = 3;
            m_rl = m_rl | (sec_byte[3:0] != 4'hF);
            m_wl = m_wl | (sec_byte[7:4] != 4'hF);
            err_n = 0;
        end
        if (m_dev == 0) mode_n = 0;
        m_dev = dev_n; m_mode = mode_n; m_addr = addr_n; m_err = err_n;
        @(negedge clk);
        host_wr = 0; host_rd = 0;
        check("core_hold", 8'(core_hold), 8'(m_dev != 0));
        check("rvalid", 8'(host_rvalid), 8'(e_v));
        if (e_v) check("rdata", host_rdata, e_d);
    endtask

    task automatic wr(int sel, bit [7:0] wd); step(1, 0, sel, wd); endtask
    task automatic rd(int sel);               step(0, 1, sel, 8'h00); endtask
    task automatic idle();                    step(0, 0, 0, 8'h00); endtask
    task automatic enter_mode();
        wr(1, 8'h00); idle(); idle();
    endtask
    task automatic leave_mode();
        wr(1, 8'h40); wr(1, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        check("reset core_hold", 8'(core_hold), 8'h00);
        check("reset rvalid", 8'(host_rvalid), 8'h00);
        rd(5); rd(2); rd(3);

        tag = "R8";   // data read with core running
        rd(4); rd(5); rd(3);

        tag = "R2";
        wr(0, 8'h04); idle();
        tag = "R3";
        enter_mode(); rd(5);

        tag = "R4";
        wr(2, 8'h12); wr(3, 8'h34); rd(2); rd(3);
        tag = "R5";
        for (int i = 0; i < 4; i++) rd(4);
        rd(2); rd(3);
        wr(2, 8'hFF); wr(3, 8'hFE);
        for (int i = 0; i < 3; i++) rd(4);
        rd(2); rd(3);

        tag = "R9";
        wr(1, 8'h40); rd(5); rd(4); wr(1, 8'h12); rd(5);
        leave_mode(); rd(5);
        tag = "R8";
        rd(4); rd(5);
        tag = "R3";
        enter_mode(); rd(5);

        tag = "R2";
        wr(0, 8'h00); idle(); wr(0, 8'h02); idle();
        tag = "R11";
        wr(0, 8'h00); idle(); rd(5); rd(4);

        tag = "R7";
        sec_byte = 8'h7F;
        wr(0, 8'h04); enter_mode(); rd(5);
        wr(3, 8'h10); rd(4); rd(4);
        leave_mode();

        tag = "R6";
        sec_byte = 8'hFB;
        enter_mode(); rd(5);
        wr(2, 8'h00); wr(3, 8'h20);
        rd(4); rd(4); rd(5); rd(3);
        leave_mode();

        tag = "R10";
        sec_byte = 8'hFF;
        enter_mode(); rd(5); rd(4); rd(5);
        leave_mode();

        tag = "R1";
        @(negedge clk) rst_n = 1'b0;
        m_dev = 0; m_mode = 0; m_addr = 0; m_err = 0; m_rl = 0; m_wl = 0;
        @(negedge clk) rst_n = 1'b1;
        rd(5); rd(2);
        tag = "R10";
        wr(0, 8'h04); enter_mode(); rd(5); rd(4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end
endmodule